// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter for a processor core. Every cycle a set of event lanes arrives, each lane carrying an 8-bit event code, an 8-bit sub-event vector and a small count of how many times that event happened in the cycle. A configuration word picks one event by code and unit mask. The counts of all matching lanes are summed. The sum is then qualified by a threshold test that can be inverted, an optional rising-edge detector and a privilege-ring filter. The result is added to a 48-bit counter.

Software loads the configuration through a write strobe. It can read the counter at any time and overwrite it. When the counter wraps past its top value it sets a sticky overflow flag. If interrupts are enabled, the flag raises an interrupt request that stays high until software clears it. A threshold of one combined with edge mode turns a multi-cycle busy indication into a count of how many times it began.

Top module: `perf_evt_counter`

## Requirements
- R1: After a synchronous active-low reset the counter, the overflow flag and the interrupt request are zero, and the configuration is all zeros, which leaves the counter disabled.
- R2: The configuration word packs these fields: bits [7:0] event code, [15:8] unit mask, [23:16] threshold, 24 invert, 25 edge, 26 ring-0 filter, 27 user-ring filter, 28 interrupt enable, 29 enable. Lane k carries its code in bits [8k+7:8k] of the code bus, its sub-events in bits [8k+7:8k] of the sub-event bus and its count in bits [4k+3:4k] of the count bus. A lane contributes its count when its code equals the configured code and its sub-event vector shares at least one set bit with the unit mask. The contributions of all lanes are summed.
- R3: With a threshold of zero, the whole per-cycle sum is added to the counter, and the invert bit has no effect.
- R4: With a nonzero threshold and invert clear, the counter adds one in a cycle whose sum is greater than or equal to the threshold, and adds nothing otherwise.
- R5: With a nonzero threshold and invert set, the counter adds one in a cycle whose sum is below the threshold, and adds nothing otherwise.
- R6: In edge mode the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle. The remembered previous condition is cleared when the configuration is written or while the counter is disabled.
- R7: With the ring-0 filter set, counting is allowed at privilege level 0. With the user-ring filter set, counting is allowed at levels 1, 2 and 3. With neither filter set, counting is allowed at every level.
- R8: While the enable bit is clear, the counter keeps its value.
- R9: The counter wraps modulo 2^48. A wrap sets a sticky overflow flag, which the clear input resets. The interrupt request equals the overflow flag gated by the interrupt enable bit.
- R10: A software counter write loads the written value at the next clock edge. Any increment from the same cycle is dropped.
- R11: Events presented in a cycle appear in the counter read port after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 30 | Configuration word |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 48 | Value loaded into the counter |
| ovf_clr | input | 1 | Clears the overflow flag |
| cpl | input | 2 | Current privilege level |
| lane_code | input | 32 | Event code of each lane |
| lane_sub | input | 32 | Sub-event vector of each lane |
| lane_cnt | input | 16 | Per-cycle event count of each lane |
| cnt_rdata | output | 48 | Current counter value |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
A software counter write can land in the same cycle as a nonzero increment. The bench provokes this by raising the counter write strobe while matching lanes carry a sum of six. It requires the written value alone after the edge, then requires the increment to resume in the following cycle. In the same way, overflow is driven by loading a value two below the wrap point and adding six. The bench checks the wrapped result of four and the flag and interrupt behaviour, both with the interrupt enable set and with it clear.

// File: rtl/pec_pkg.sv
// Shared types for the qualified event counter.
// Assumes the configuration word layout given in the brief (R2).
package pec_pkg;

    localparam int CODE_W = 8;
    localparam int THR_W  = 8;

    // Field order from MSB to LSB matches configuration bits [29:0].
    typedef struct packed {
        logic              en;
        logic              int_en;
        logic              usr_f;
        logic              os_f;
        logic              edge_f;
        logic              inv;
        logic [THR_W-1:0]  thr;
        logic [CODE_W-1:0] umask;
        logic [CODE_W-1:0] code;
    } pec_cfg_t;

    localparam int CFG_W = $bits(pec_cfg_t);

endpackage

// File: rtl/pec_event_select.sv
// Event selector: sums the counts of all lanes whose code matches the
// configured code and whose sub-event vector overlaps the unit mask.
// Assumes lanes are packed contiguously, lane 0 in the low bits.
module pec_event_select
    import pec_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int LANE_W  = 4,
    localparam int SUM_W  = LANE_W + $clog2(NUM_SRC)
) (
    input  logic [CODE_W-1:0]         code_i,
    input  logic [CODE_W-1:0]         mask_i,
    input  logic [NUM_SRC*CODE_W-1:0] lane_code_i,
    input  logic [NUM_SRC*CODE_W-1:0] lane_sub_i,
    input  logic [NUM_SRC*LANE_W-1:0] lane_cnt_i,
    output logic [SUM_W-1:0]          sum_o
);

    logic [LANE_W-1:0] masked [NUM_SRC];

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_lane
        logic [CODE_W-1:0] l_code;
        logic [CODE_W-1:0] l_sub;
        logic              l_hit;
        assign l_code = lane_code_i[k*CODE_W +: CODE_W];
        assign l_sub  = lane_sub_i[k*CODE_W +: CODE_W];
        // Lane match: code equal and at least one shared sub-event bit.
        assign l_hit     = (l_code == code_i) && (|(l_sub & mask_i));
        assign masked[k] = l_hit ? lane_cnt_i[k*LANE_W +: LANE_W] : '0;
    end

    // Adder tree flattened into a loop: total of matching lanes.
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            sum_o = sum_o + SUM_W'(masked[k]);
        end
    end

endmodule

// File: rtl/pec_qualifier.sv
// Qualifier: applies the privilege filter, threshold/invert test and
// optional rising-edge detection to the per-cycle event sum, and
// produces the amount to add to the counter.
// Assumes cfg_i is the registered configuration.
module pec_qualifier
    import pec_pkg::*;
#(
    parameter int SUM_W = 6,
    localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pec_cfg_t         cfg_i,
    input  logic [1:0]       cpl_i,
    input  logic [SUM_W-1:0] sum_i,
    input  logic             clr_hist_i,
    output logic [SUM_W-1:0] inc_o
);

    logic             priv_ok;
    logic             thr_zero;
    logic             meets;
    logic             cond;
    logic             live;
    logic             prev_q;
    logic [CMP_W-1:0] sum_x;
    logic [CMP_W-1:0] thr_x;

    // Privilege filter: no filter bit set means every ring counts.
    always_comb begin
        if (!cfg_i.os_f && !cfg_i.usr_f) begin
            priv_ok = 1'b1;
        end else begin
            priv_ok = (cfg_i.os_f && (cpl_i == 2'd0)) ||
                      (cfg_i.usr_f && (cpl_i != 2'd0));
        end
    end

    // Threshold test, reversed by invert only when threshold is nonzero.
    always_comb begin
        sum_x    = CMP_W'(sum_i);
        thr_x    = CMP_W'(cfg_i.thr);
        thr_zero = (cfg_i.thr == '0);
        meets    = (sum_x >= thr_x);
        cond     = thr_zero ? (sum_i != '0) : (meets ^ cfg_i.inv);
        live     = cfg_i.en && priv_ok && cond;
    end

    // Edge history: remembers last cycle's qualified condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (clr_hist_i || !cfg_i.en) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= live;
        end
    end

    // Increment selection: edge pulse, raw sum, or single unit.
    always_comb begin
        if (!cfg_i.en || !priv_ok) begin
            inc_o = '0;
        end else if (cfg_i.edge_f) begin
            inc_o = SUM_W'(live && !prev_q);
        end else if (thr_zero) begin
            inc_o = sum_i;
        end else begin
            inc_o = SUM_W'(cond);
        end
    end

    p_thr_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.thr != '0) |-> (inc_o <= SUM_W'(1)));

    p_edge_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.edge_f && (inc_o != '0) && !clr_hist_i) |=> (inc_o == '0));

    p_ring0_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.os_f && !cfg_i.usr_f && (cpl_i != 2'd0)) |-> (inc_o == '0));

endmodule

// File: rtl/pec_accum.sv
// Accumulator: wide counter with software load priority and a sticky
// overflow flag set on carry out of the top bit.
// Assumes inc_i is already zero whenever counting is disabled.
module pec_accum #(
    parameter int CNT_W = 48,
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] inc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic [CNT_W:0] add;

    // Next value with carry out for wrap detection.
    assign add = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

    // Counter register: software write wins over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (wr_i) begin
            cnt_o <= wdata_i;
        end else begin
            cnt_o <= add[CNT_W-1:0];
        end
    end

    // Sticky overflow flag: a wrap outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
        end else if (!wr_i && add[CNT_W]) begin
            ovf_o <= 1'b1;
        end else if (ovf_clr_i) begin
            ovf_o <= 1'b0;
        end
    end

    p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (cnt_o < $past(cnt_o)));

endmodule

// File: rtl/perf_evt_counter.sv
// Top of the qualified event counter: holds the configuration register
// and joins the selector, the qualifier and the accumulator.
// Assumes a single clock and synchronous active-low reset.
module perf_evt_counter
    import pec_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int LANE_W  = 4,
    parameter int CNT_W   = 48,
    localparam int SUM_W  = LANE_W + $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic                      cnt_we,
    input  logic [CNT_W-1:0]          cnt_wdata,
    input  logic                      ovf_clr,
    input  logic [1:0]                cpl,
    input  logic [NUM_SRC*CODE_W-1:0] lane_code,
    input  logic [NUM_SRC*CODE_W-1:0] lane_sub,
    input  logic [NUM_SRC*LANE_W-1:0] lane_cnt,
    output logic [CNT_W-1:0]          cnt_rdata,
    output logic                      ovf,
    output logic                      irq
);

    pec_cfg_t         cfg_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] inc;

    // Configuration register, loaded whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= pec_cfg_t'(cfg_wdata);
        end
    end

    pec_event_select #(
        .NUM_SRC (NUM_SRC),
        .LANE_W  (LANE_W)
    ) u_sel (
        .code_i      (cfg_q.code),
        .mask_i      (cfg_q.umask),
        .lane_code_i (lane_code),
        .lane_sub_i  (lane_sub),
        .lane_cnt_i  (lane_cnt),
        .sum_o       (sum)
    );

    pec_qualifier #(
        .SUM_W (SUM_W)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg_q),
        .cpl_i      (cpl),
        .sum_i      (sum),
        .clr_hist_i (cfg_we),
        .inc_o      (inc)
    );

    pec_accum #(
        .CNT_W (CNT_W),
        .SUM_W (SUM_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc),
        .wr_i      (cnt_we),
        .wdata_i   (cnt_wdata),
        .ovf_clr_i (ovf_clr),
        .cnt_o     (cnt_rdata),
        .ovf_o     (ovf)
    );

    // Interrupt request: overflow gated by the interrupt enable.
    assign irq = ovf && cfg_q.int_en;

    p_irq_needs_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf);

    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.en && !cnt_we) |=> $stable(cnt_rdata));

endmodule

// File: tb/test_perf_evt_counter.sv
module test_perf_evt_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [29:0] cfg_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [47:0] cnt_wdata = '0;
    logic        ovf_clr = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic [31:0] lane_code;
    logic [31:0] lane_sub;
    logic [15:0] lane_cnt = '0;
    logic [47:0] cnt_rdata;
    logic        ovf;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Lanes 0..2 carry code 0x24 (sub 0x01, 0x01, 0x80); lane 3 carries 0x3C.
    assign lane_code = {8'h3C, 8'h24, 8'h24, 8'h24};
    assign lane_sub  = {8'h01, 8'h80, 8'h01, 8'h01};

    always #4 clk = ~clk;

    perf_evt_counter i_perf_evt_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .ovf_clr   (ovf_clr),
        .cpl       (cpl),
        .lane_code (lane_code),
        .lane_sub  (lane_sub),
        .lane_cnt  (lane_cnt),
        .cnt_rdata (cnt_rdata),
        .ovf       (ovf),
        .irq       (irq)
    );

    // Vector: thr[39:32] inv[31] os[30] usr[29] cpl[28:27] lanes[26:11] exp[7:0]
    localparam int NVEC = 14;
    localparam logic [39:0] VEC [NVEC] = '{
        {8'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd6},  // R3 raw sum
        {8'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd6},  // R3 invert ignored
        {8'd4, 1'b0, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd1},  // R4 above
        {8'd7, 1'b0, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd0},  // R4 below
        {8'd7, 1'b1, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd1},  // R5 below
        {8'd6, 1'b1, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd0},  // R5 equal
        {8'd6, 1'b0, 1'b0, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd1},  // R4 equal
        {8'd0, 1'b0, 1'b1, 1'b0, 2'd0, 16'h5123, 3'd0, 8'd6},  // R7 ring0 ok
        {8'd0, 1'b0, 1'b1, 1'b0, 2'd2, 16'h5123, 3'd0, 8'd0},  // R7 ring0 blocks 2
        {8'd0, 1'b0, 1'b0, 1'b1, 2'd3, 16'h5123, 3'd0, 8'd6},  // R7 user ok
        {8'd0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h5123, 3'd0, 8'd0},  // R7 user blocks 0
        {8'd0, 1'b0, 1'b1, 1'b1, 2'd1, 16'h5123, 3'd0, 8'd6},  // R7 both
        {8'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h5000, 3'd0, 8'd0},  // R2 lane3 ignored
        {8'd1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h5000, 3'd0, 8'd1}   // R5 zero sum
    };

    function automatic logic [29:0] mk_cfg(
        input logic [7:0] code, input logic [7:0] mask, input logic [7:0] thr,
        input logic inv, input logic edg, input logic os, input logic usr,
        input logic ie, input logic en);
        return {en, ie, usr, os, edg, inv, thr, mask, code};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic cfg_wr(input logic [29:0] d);
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cnt_wr(input logic [47:0] d);
        cnt_wdata = d;
        cnt_we    = 1'b1;
        @(negedge clk);
        cnt_we    = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] lanes);
        lane_cnt = lanes;
        @(negedge clk);
        lane_cnt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, and configuration disabled by default.
        check("R1 counter", cnt_rdata, 0);
        check("R1 ovf", ovf, 0);
        check("R1 irq", irq, 0);
        pulse(16'h5123);
        check("R1 disabled after reset", cnt_rdata, 0);

        // Table walk: R2..R7 with one event cycle each, R11 one-edge latency.
        for (int i = 0; i < NVEC; i++) begin
            logic [39:0] v;
            v = VEC[i];
            cfg_wr(mk_cfg(8'h24, 8'hFF, v[39:32], v[31], 1'b0, v[30], v[29], 1'b0, 1'b1));
            cpl = v[28:27];
            cnt_wr(48'd0);
            pulse(v[26:11]);
            check($sformatf("R11 vector %0d", i), cnt_rdata, 48'(v[7:0]));
        end
        cpl = 2'd0;

        // R2: unit mask selects only lanes sharing a sub-event bit.
        cfg_wr(mk_cfg(8'h24, 8'h80, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cnt_wr(48'd0);
        pulse(16'h5123);
        check("R2 mask 0x80", cnt_rdata, 1);
        cfg_wr(mk_cfg(8'h24, 8'h01, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cnt_wr(48'd0);
        pulse(16'h5123);
        check("R2 mask 0x01", cnt_rdata, 5);
        cfg_wr(mk_cfg(8'h3C, 8'h01, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cnt_wr(48'd0);
        pulse(16'h5123);
        check("R2 code 0x3C", cnt_rdata, 5);

        // R6: edge with threshold 1 counts starts of busy periods.
        cfg_wr(mk_cfg(8'h24, 8'hFF, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        cnt_wr(48'd0);
        lane_cnt = 16'h0001;
        repeat (4) @(negedge clk);
        check("R6 held busy counts once", cnt_rdata, 1);
        lane_cnt = 16'h0000;
        @(negedge clk);
        lane_cnt = 16'h0001;
        repeat (2) @(negedge clk);
        check("R6 second start", cnt_rdata, 2);
        cfg_wr(mk_cfg(8'h24, 8'hFF, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        @(negedge clk);
        check("R6 config write clears history", cnt_rdata, 3);
        lane_cnt = 16'h0000;
        repeat (2) @(negedge clk);
        check("R6 idle", cnt_rdata, 3);

        // R8: disabled counter keeps a loaded value.
        cfg_wr(mk_cfg(8'h24, 8'hFF, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        cnt_wr(48'd50);
        lane_cnt = 16'h5123;
        repeat (3) @(negedge clk);
        lane_cnt = '0;
        check("R8 disabled hold", cnt_rdata, 50);

        // R10: software write and increment in the same cycle.
        cfg_wr(mk_cfg(8'h24, 8'hFF, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        lane_cnt  = 16'h5123;
        cnt_wdata = 48'd100;
        cnt_we    = 1'b1;
        @(negedge clk);
        cnt_we    = 1'b0;
        check("R10 write wins", cnt_rdata, 100);
        @(negedge clk);
        lane_cnt = '0;
        check("R10 increment resumes", cnt_rdata, 106);

        // R9: wrap with interrupt enabled, then clear.
        cfg_wr(mk_cfg(8'h24, 8'hFF, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        cnt_wr(48'hFFFF_FFFF_FFFE);
        check("R9 no ovf before wrap", ovf, 0);
        pulse(16'h5123);
        check("R9 wrapped value", cnt_rdata, 4);
        check("R9 ovf set", ovf, 1);
        check("R9 irq set", irq, 1);
        repeat (2) @(negedge clk);
        check("R9 ovf sticky", ovf, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R9 ovf cleared", ovf, 0);
        check("R9 irq cleared", irq, 0);

        // R9: wrap with interrupt disabled.
        cfg_wr(mk_cfg(8'h24, 8'hFF, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        cnt_wr(48'hFFFF_FFFF_FFFE);
        pulse(16'h5123);
        check("R9 ovf without irq", ovf, 1);
        check("R9 irq masked", irq, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule